// File: doc/BRIEF.md
# Circular-Window FIR Multiply-Accumulate Engine

This block produces one finite impulse response output for every input sample it accepts. It keeps the most recent TAPS samples in a small ring of registers and the TAPS coefficients in a second, separate bank. Because the two banks are separate, one sample and one coefficient are fetched together in every cycle of the loop. A single multiply-accumulate unit then walks both banks. The accumulator is 56 bits wide: an 8-bit guard extension above a 24-bit high word and a 24-bit low word. All data words are 24-bit signed fractions with 23 fraction bits.

A start strobe hands in a sample, which is written at the current ring position, and the accumulator is cleared. The sequencer loads the first operand pair, runs TAPS-1 plain multiply-accumulates, each of which also fetches the next pair, and ends with one multiply-accumulate that also rounds. The ring pointer advances once per fetch, so it returns to where it started. After the loop it steps back by one, so that the next sample replaces the oldest one. One cycle later the saturated high word is registered on the output, together with a one-cycle done pulse. Coefficients are written through a simple write port while the engine is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, busy and done are low, result is zero, and every sample and coefficient entry reads as zero. Any output computed before coefficients are written is therefore zero.
- R2: A start that arrives while busy is low is accepted on that rising edge. Busy is high from the following cycle until the cycle in which done is high, and busy is low in that cycle.
- R3: Done rises on exactly the (TAPS+3)th rising edge, counting the accepting edge as the first. It is high for exactly one cycle. Result changes only on the edge that raises done and is held otherwise.
- R4: The result equals sat(round(2 * sum over i of c[i] * x[n-i])) for i from 0 to TAPS-1, with all values taken as 24-bit two's-complement fractions. Here x[n] is the sample just accepted, and c[i] is the coefficient written at address i.
- R5: Each product is the full 48-bit signed product shifted left by one. Therefore -1.0 times -1.0 contributes +1.0, which is 2^47 in accumulator units, and does not wrap.
- R6: Rounding adds 2^23 to the accumulator and then clears its low 24 bits. An exact half of a result LSB therefore rounds toward plus infinity: 0x400000 times coefficient 0x000001 gives 1, 0x3FFFFF times 0x000001 gives 0, and 0xC00000 times 0x000001 gives 0.
- R7: If the rounded accumulator does not fit in 24 bits (bits 55 to 47 not all equal), the result is 0x7FFFFF for a positive value and 0x800000 for a negative value.
- R8: The sample ring is addressed modulo TAPS, with a modifier value of TAPS-1. After each output the write position is one below the position used for that sample, taken modulo TAPS. Only the last TAPS accepted samples contribute.
- R9: A start that arrives while busy is high is ignored. No sample is stored and the current computation is unchanged.
- R10: A coefficient write (coef_we high, 24-bit coef_wdata to coef_addr) takes effect only while busy is low. A write attempted while busy changes neither the current result nor any later one.
- R11: Every output uses exactly TAPS-1 plain multiply-accumulates followed by one rounding multiply-accumulate. Done follows the rounding step two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept sample_in and begin one output |
| sample_in | input | 24 | New signed fractional sample |
| coef_we | input | 1 | Coefficient write strobe, honoured only when idle |
| coef_addr | input | $clog2(TAPS) | Coefficient index (0 pairs with newest sample) |
| coef_wdata | input | 24 | Coefficient value |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 24 | Rounded, saturated output sample |

## Verification
A ring pointer that is off by one shows up as a wrong result. The error appears at the first done after the window has more than one nonzero sample, and it persists for every later output. A wrong loop count or a misplaced rounding step shows as a done pulse off its TAPS+3 edge slot, or as an LSB error in that same result. Saturation and rounding faults appear only on the directed corner cases, in the very output that exercises them. Writes and starts that leak in while busy corrupt the output that is in progress or the next one.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  localparam int DW   = 24;
  localparam int EXTW = 8;
  localparam int ACCW = EXTW + 2 * DW;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOOP,
    ST_LAST,
    ST_EMIT
  } fir_state_e;

  // Fractional product: signed 48-bit product, one left shift, into accumulator width.
  function automatic logic [ACCW-1:0] frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = {{DW{a[DW-1]}}, a} * {{DW{b[DW-1]}}, b};
    return {{(ACCW-2*DW-1){p[2*DW-1]}}, p, 1'b0};
  endfunction

  // Add half a high-word LSB, then drop the low word.
  function automatic logic [ACCW-1:0] round_acc(input logic [ACCW-1:0] a);
    logic [ACCW-1:0] t;
    t = a + (ACCW'(1) << (DW - 1));
    return {t[ACCW-1:DW], {DW{1'b0}}};
  endfunction

  // Clamp the high word when the guard bits disagree with its sign.
  function automatic logic [DW-1:0] sat_high(input logic [ACCW-1:0] a);
    logic [ACCW-2*DW:0] top;
    top = a[ACCW-1:2*DW-1];
    if (&top || ~|top) return a[2*DW-1:DW];
    else if (a[ACCW-1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction

endpackage

// File: rtl/fir_tap_mem.sv
module fir_tap_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/fir_ring_ptr.sv
module fir_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] MODV = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (clr) ptr_q <= '0;
    else if (inc) ptr_q <= (ptr_q == MODV) ? '0 : ptr_q + AW'(1);
    else if (dec) ptr_q <= (ptr_q == '0) ? MODV : ptr_q - AW'(1);
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit
  import fir_mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load_ops,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   y_in,
  input  logic            acc_en,
  input  logic            rnd_en,
  output logic [ACCW-1:0] acc
);

  logic [DW-1:0]   x_q, y_q;
  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] sum;

  assign sum = acc_q + frac_mul(x_q, y_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      acc_q <= '0;
    end else begin
      if (clr)         acc_q <= '0;
      else if (acc_en) acc_q <= rnd_en ? round_acc(sum) : sum;
      if (load_ops) begin
        x_q <= x_in;
        y_q <= y_in;
      end
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_mac_pkg::*;
#(
  parameter int TAPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic fetch,
  output logic loop_mac,
  output logic final_mac,
  output logic emit,
  output logic busy
);

  localparam int CW = (TAPS > 2) ? $clog2(TAPS) : 1;

  fir_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = start && !busy;
  assign fetch     = (st_q == ST_LOAD) || (st_q == ST_LOOP);
  assign loop_mac  = (st_q == ST_LOOP);
  assign final_mac = (st_q == ST_LAST);
  assign emit      = (st_q == ST_EMIT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_LOAD;
      ST_LOAD: st_d = ST_LOOP;
      ST_LOOP: if (cnt_q == '0) st_d = ST_LAST;
      ST_LAST: st_d = ST_EMIT;
      ST_EMIT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LOAD)      cnt_q <= CW'(TAPS - 2);
      else if (st_q == ST_LOOP) cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int TAPS = 8,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] sample_in,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [DW-1:0] coef_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);

  // Named internal events, also observed by the bound checker.
  logic            accept;
  logic            fetch;
  logic            loop_mac;
  logic            final_mac;
  logic            emit;
  logic [AW-1:0]   samp_ptr;
  logic [AW-1:0]   coef_ptr;
  logic [DW-1:0]   samp_rd;
  logic [DW-1:0]   coef_rd;
  logic [ACCW-1:0] acc;
  logic            coef_wr_ok;

  logic            done_q;
  logic [DW-1:0]   result_q;

  assign coef_wr_ok = coef_we && !busy;

  fir_seq #(.TAPS(TAPS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .fetch     (fetch),
    .loop_mac  (loop_mac),
    .final_mac (final_mac),
    .emit      (emit),
    .busy      (busy)
  );

  fir_ring_ptr #(.DEPTH(TAPS)) u_samp_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .inc   (fetch),
    .dec   (final_mac),
    .ptr   (samp_ptr)
  );

  fir_ring_ptr #(.DEPTH(TAPS)) u_coef_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (fetch),
    .dec   (1'b0),
    .ptr   (coef_ptr)
  );

  fir_tap_mem #(.DEPTH(TAPS), .WIDTH(DW)) u_samp_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept),
    .waddr (samp_ptr),
    .wdata (sample_in),
    .raddr (samp_ptr),
    .rdata (samp_rd)
  );

  fir_tap_mem #(.DEPTH(TAPS), .WIDTH(DW)) u_coef_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_wr_ok),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .raddr (coef_ptr),
    .rdata (coef_rd)
  );

  fir_mac_unit u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .load_ops (fetch),
    .x_in     (samp_rd),
    .y_in     (coef_rd),
    .acc_en   (loop_mac || final_mac),
    .rnd_en   (final_mac),
    .acc      (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= emit;
      if (emit) result_q <= sat_high(acc);
    end
  end

  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int TAPS = 8,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [23:0]   result,
  input logic          loop_mac,
  input logic          final_mac,
  input logic [AW-1:0] samp_ptr
);

  int            lat_q;
  int            macs_q;
  logic [AW-1:0] ptr_exp_q;
  logic          acc_ev;

  assign acc_ev = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= 0;
      macs_q    <= 0;
      ptr_exp_q <= '0;
    end else begin
      if (acc_ev)    lat_q <= 1;
      else if (busy) lat_q <= lat_q + 1;
      if (acc_ev)        macs_q <= 0;
      else if (loop_mac) macs_q <= macs_q + 1;
      if (acc_ev) ptr_exp_q <= (samp_ptr == '0) ? AW'(TAPS - 1) : samp_ptr - AW'(1);
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |=> busy);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == TAPS + 3));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_step_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (samp_ptr == ptr_exp_q));

  assert_loop_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    final_mac |-> (macs_q == TAPS - 1));

  assert_round_then_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    final_mac |-> ##2 done);

  assert_single_mac_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({loop_mac, final_mac, done}) <= 1);

endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .loop_mac  (loop_mac),
  .final_mac (final_mac),
  .samp_ptr  (samp_ptr)
);

// File: tb/fir_mac_engine_bench.sv
`timescale 1ns/1ps
module fir_mac_engine_bench;

  localparam int TAPS = 8;
  localparam int AW   = $clog2(TAPS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [23:0]   sample_in = '0;
  logic          coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [23:0]   coef_wdata = '0;
  logic          busy, done;
  logic [23:0]   result;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [23:0] hist [TAPS];
  logic [23:0] cm   [TAPS];

  always #2 clk = ~clk;

  fir_mac_engine #(.TAPS(TAPS)) u_fir_mac_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_in(sample_in),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic longint sx(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  // Model: fractional dot product, doubled, half-LSB added, floor, clamp.
  function automatic logic [23:0] model_out();
    longint s = 0;
    for (int i = 0; i < TAPS; i++) s += sx(hist[i]) * sx(cm[i]);
    s = (s * 2 + (longint'(1) << 23)) >>> 24;
    if (s > 64'sd8388607)  s = 64'sd8388607;
    if (s < -64'sd8388608) s = -64'sd8388608;
    return s[23:0];
  endfunction

  task automatic load_coef(input int idx, input logic [23:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = AW'(idx); coef_wdata = v;
    @(negedge clk);
    coef_we = 1'b0;
    cm[idx] = v;
  endtask

  task automatic run_sample(input logic [23:0] x, input bit disturb, input string tag);
    int edges;
    logic [23:0] expv;
    @(negedge clk);
    start = 1'b1; sample_in = x;
    @(posedge clk);
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    expv = model_out();
    edges = 1;
    @(negedge clk);
    start = 1'b0; sample_in = '0;
    chk(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    while (done !== 1'b1 && edges < TAPS + 10) begin
      if (disturb && edges == 3) begin
        // R9 and R10: both must be ignored while busy
        start = 1'b1; sample_in = ~x;
        coef_we = 1'b1; coef_addr = '0; coef_wdata = ~cm[0];
      end else begin
        start = 1'b0; coef_we = 1'b0;
      end
      @(posedge clk); edges++;
      @(negedge clk);
    end
    start = 1'b0; coef_we = 1'b0;
    chk(edges == TAPS + 3, "R3 done latency", edges, TAPS + 3);
    chk(busy === 1'b0, "R2 idle with done", longint'(busy), 0);
    chk(result === expv, tag, longint'(result), longint'(expv));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < TAPS; i++) begin hist[i] = '0; cm[i] = '0; end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
    chk(result === 24'h0, "R1 reset result", result, 0);
    rst_n = 1'b1;

    // R1: zero coefficients yield zero
    run_sample(24'h7FFFFF, 0, "R1 zero coefs");
    run_sample(24'h123456, 0, "R1 zero coefs 2");

    // R8 and R10: impulse walks through the ring, coefficient i meets age i
    for (int i = 0; i < TAPS; i++) load_coef(i, 24'(32'h010000 * (i + 1)));
    run_sample(24'h7FFFFF, 0, "R8 impulse head");
    for (int i = 1; i < TAPS + 2; i++) run_sample(24'h0, 0, "R8 impulse tail");

    // R6: rounding of an exact half LSB and just below
    for (int i = 0; i < TAPS; i++) load_coef(i, 24'h0);
    load_coef(0, 24'h000001);
    run_sample(24'h400000, 0, "R6 half rounds up");
    chk(result === 24'h000001, "R6 half value", result, 1);
    run_sample(24'h3FFFFF, 0, "R6 below half");
    chk(result === 24'h000000, "R6 below value", result, 0);
    run_sample(24'hC00000, 0, "R6 negative half");
    chk(result === 24'h000000, "R6 negative half value", result, 0);

    // R7 and R5: saturation both ways, -1 times -1
    for (int i = 0; i < TAPS; i++) load_coef(i, 24'h7FFFFF);
    for (int i = 0; i < TAPS; i++) run_sample(24'h7FFFFF, 0, "R7 positive clamp");
    chk(result === 24'h7FFFFF, "R7 positive value", result, 24'h7FFFFF);
    for (int i = 0; i < TAPS; i++) load_coef(i, 24'h800000);
    run_sample(24'h7FFFFF, 0, "R7 negative clamp");
    chk(result === 24'h800000, "R7 negative value", result, 24'h800000);
    for (int i = 0; i < TAPS; i++) load_coef(i, 24'h0);
    load_coef(0, 24'h800000);
    run_sample(24'h800000, 0, "R5 minus one squared");
    chk(result === 24'h7FFFFF, "R5 clamps to max", result, 24'h7FFFFF);

    // R4 R11: random coefficients of varied amplitude and random samples
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < TAPS; i++) load_coef(i, 24'($signed(24'($urandom())) >>> ($urandom() % 6)));
      for (int k = 0; k < 12; k++) begin
        logic [23:0] x;
        x = 24'($signed(24'($urandom())) >>> ($urandom() % 4));
        run_sample(x, (k % 5 == 2), (k % 5 == 2) ? "R9 R10 disturbed" : "R4 R11 random");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule